// File: doc/BRIEF.md
# Set-Associative Tag Store with Selective Line Invalidation

This block holds the tags and valid bits of a physically tagged, set-associative cache, and it controls how lines are invalidated. An invalidate request carries a full address and is accepted through a ready/valid handshake. The block reads the indexed set and compares the tag in every way. It then clears the valid bit of the one way that holds the address. If no way holds the address, nothing changes. A build-time option selects a simpler variant instead, which clears every way of the indexed set whatever the tags are.

When reset ends, a counter walks once through all set indices and clears them, so the cache is fully invalid without a software loop. Software can start the same walk later by pulsing a control input. While the walk runs, the block reports busy, every lookup misses, invalidate requests are held off and fills are dropped. A combinational lookup port reports hit and way. A fill port writes a tag and marks a way valid. Data arrays, refill sequencing, the bus interface and address translation are outside the block.

Top module: `tag_inv_store`

## Requirements
- R1: An accepted invalidate whose address hits clears the valid bit of the matching way only. Other ways of the same set and all other sets keep their state.
- R2: With SET_CLEAR=0, an accepted invalidate whose address misses changes no valid bit.
- R3: The address fields, from least significant upward, are: byte offset (log2 LINE_BYTES bits), set index (log2 SETS bits), then tag (the rest). `lk_hit` is 1 when the indexed set has a valid way with an equal tag. `lk_way` gives the lowest such way.
- R4: With SET_CLEAR=1, an accepted invalidate clears every way of the indexed set, whatever the tags are.
- R5: When reset is released, `busy` stays high for exactly SETS cycles while every set is cleared. After that, every lookup misses until a fill.
- R6: Pulsing `sweep_req` while idle raises `busy` on the next cycle. The same SETS-cycle walk then clears the whole store.
- R7: While `busy` is high, `lk_hit` is 0, `inv_ready` is 0 and fills are ignored.
- R8: An invalidate is accepted on the edge where `inv_valid` and `inv_ready` are both high. Its valid-bit write lands on the following edge. A lookup in the cycle between those edges still sees the old state.
- R9: A fill writes the tag and sets the valid bit of the chosen way and set. If the valid-bit write of an invalidate targets the same set and way on the same edge, the bit ends up cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; the sweep starts when it is released |
| lk_addr | input | ADDR_W | Lookup address |
| lk_hit | output | 1 | Lookup hit |
| lk_way | output | WAY_W | Way of the lookup hit (lowest matching) |
| inv_valid | input | 1 | Invalidate request |
| inv_addr | input | ADDR_W | Address to invalidate |
| inv_ready | output | 1 | Invalidate can be accepted |
| fill_en | input | 1 | Write a tag and set its valid bit |
| fill_way | input | WAY_W | Way written by a fill |
| fill_addr | input | ADDR_W | Address whose index and tag a fill writes |
| sweep_req | input | 1 | Software request to invalidate the whole store |
| busy | output | 1 | Sweep in progress |

## Verification
A wrong valid bit or tag in this block appears at the lookup port on the first cycle that probes its set. A line that should have survived shows as a miss, and a line that should have gone shows as a hit, one cycle after the invalidate write edge. A sweep counter that is off by even one shows at once as a wrong length of `busy` and `inv_ready`, or as one set that keeps a stale hit after the sweep. The bench therefore compares every lookup output on every cycle against a behavioural model. Its directed lookups aim at the sets that were just written or invalidated, so any such divergence surfaces within two cycles.

// File: rtl/tag_inv_pkg.sv
package tag_inv_pkg;
  typedef enum logic {SW_IDLE = 1'b0, SW_RUN = 1'b1} sweep_state_e;
endpackage

// File: rtl/tag_way_compare.sv
module tag_way_compare #(
  parameter int WAYS  = 2,
  parameter int TAG_W = 20
) (
  input  logic [WAYS*TAG_W-1:0] row_tags,
  input  logic [WAYS-1:0]       row_vld,
  input  logic [TAG_W-1:0]      probe_tag,
  output logic [WAYS-1:0]       match
);
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign match[w] = row_vld[w] && (row_tags[w*TAG_W +: TAG_W] == probe_tag);
  end
endmodule

// File: rtl/tag_way_pick.sv
module tag_way_pick #(
  parameter int WAYS  = 2,
  parameter int WAY_W = 1
) (
  input  logic [WAYS-1:0]  match,
  output logic             any,
  output logic [WAY_W-1:0] way
);
  always_comb begin
    any = |match;
    way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w]) way = WAY_W'(w);
    end
  end
endmodule

// File: rtl/tag_sweep_ctrl.sv
module tag_sweep_ctrl
  import tag_inv_pkg::*;
#(
  parameter int SETS  = 64,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic [IDX_W-1:0] clr_idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(SETS - 1);

  sweep_state_e state_q;
  logic [IDX_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SW_RUN;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        SW_IDLE: if (start) begin
          state_q <= SW_RUN;
          cnt_q   <= '0;
        end
        SW_RUN: if (cnt_q == LAST) begin
          state_q <= SW_IDLE;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
        default: state_q <= SW_IDLE;
      endcase
    end
  end

  assign busy    = (state_q == SW_RUN);
  assign clr_idx = cnt_q;
endmodule

// File: rtl/tag_inv_store.sv
module tag_inv_store #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int SETS       = 64,
  parameter int WAYS       = 2,
  parameter bit SET_CLEAR  = 1'b0,
  localparam int WAY_W     = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic [WAY_W-1:0]  lk_way,
  input  logic              inv_valid,
  input  logic [ADDR_W-1:0] inv_addr,
  output logic              inv_ready,
  input  logic              fill_en,
  input  logic [WAY_W-1:0]  fill_way,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic              sweep_req,
  output logic              busy
);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

  function automatic logic [IDX_W-1:0] idx_of(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: IDX_W];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [WAYS-1:0]  vld_q [SETS];
  logic [WAYS-1:0]  vld_d [SETS];

  // Named internal events
  logic             sw_clr;
  logic [IDX_W-1:0] sw_idx;
  logic             inv_fire;
  logic             fill_fire;
  logic [WAYS-1:0]  inv_match;
  logic [WAYS-1:0]  inv_mask;
  logic [WAYS-1:0]  lk_match;
  logic             lk_any;
  logic             stg_vld;
  logic [IDX_W-1:0] stg_idx;
  logic [WAYS-1:0]  stg_mask;

  logic [IDX_W-1:0] lk_idx, inv_idx, fill_idx;
  logic [WAYS*TAG_W-1:0] lk_row_tags, inv_row_tags;
  logic [WAYS-1:0]  lk_row_vld, inv_row_vld;

  assign lk_idx   = idx_of(lk_addr);
  assign inv_idx  = idx_of(inv_addr);
  assign fill_idx = idx_of(fill_addr);

  tag_sweep_ctrl #(.SETS(SETS), .IDX_W(IDX_W)) u_sweep (
    .clk(clk), .rst_n(rst_n), .start(sweep_req),
    .busy(sw_clr), .clr_idx(sw_idx)
  );

  assign busy      = sw_clr;
  assign inv_ready = !sw_clr;
  assign inv_fire  = inv_valid && !sw_clr;
  assign fill_fire = fill_en && !sw_clr;

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      lk_row_tags[w*TAG_W +: TAG_W]  = tag_q[lk_idx][w];
      inv_row_tags[w*TAG_W +: TAG_W] = tag_q[inv_idx][w];
    end
    lk_row_vld  = vld_q[lk_idx];
    inv_row_vld = vld_q[inv_idx];
  end

  tag_way_compare #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lk_cmp (
    .row_tags(lk_row_tags), .row_vld(lk_row_vld),
    .probe_tag(tag_of(lk_addr)), .match(lk_match)
  );

  tag_way_pick #(.WAYS(WAYS), .WAY_W(WAY_W)) u_lk_pick (
    .match(lk_match), .any(lk_any), .way(lk_way)
  );

  assign lk_hit = lk_any && !sw_clr;

  tag_way_compare #(.WAYS(WAYS), .TAG_W(TAG_W)) u_inv_cmp (
    .row_tags(inv_row_tags), .row_vld(inv_row_vld),
    .probe_tag(tag_of(inv_addr)), .match(inv_match)
  );

  if (SET_CLEAR) begin : g_set_clear
    assign inv_mask = '1;
  end else begin : g_exact
    assign inv_mask = inv_match;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_vld  <= 1'b0;
      stg_idx  <= '0;
      stg_mask <= '0;
    end else begin
      stg_vld  <= inv_fire;
      stg_idx  <= inv_idx;
      stg_mask <= inv_fire ? inv_mask : '0;
    end
  end

  // Fill first, then the invalidate write, then the sweep: later steps win.
  always_comb begin
    vld_d = vld_q;
    if (fill_fire) vld_d[fill_idx][fill_way] = 1'b1;
    if (stg_vld)   vld_d[stg_idx] = vld_d[stg_idx] & ~stg_mask;
    if (sw_clr)    vld_d[sw_idx] = '0;
  end

  always_ff @(posedge clk) begin
    vld_q <= vld_d;
    if (fill_fire) tag_q[fill_idx][fill_way] <= tag_of(fill_addr);
  end
endmodule

// File: rtl/tag_inv_checker.sv
module tag_inv_checker #(
  parameter int ADDR_W    = 32,
  parameter int SETS      = 64,
  parameter int WAYS      = 2,
  parameter bit SET_CLEAR = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              lk_hit,
  input logic [ADDR_W-1:0] lk_addr,
  input logic              inv_valid,
  input logic              inv_ready,
  input logic [ADDR_W-1:0] inv_addr,
  input logic              sweep_req,
  input logic [WAYS-1:0]   stg_mask
);
  localparam int RUN_W = $clog2(SETS) + 1;
  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= busy ? run_q + 1'b1 : '0;
  end

  assert_busy_miss_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !lk_hit);

  assert_sweep_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_q < RUN_W'(SETS)));

  assert_sweep_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sweep_req && !busy) |=> busy);

  assert_miss_noop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!SET_CLEAR && inv_valid && inv_ready && (lk_addr == inv_addr) && !lk_hit)
      |=> (stg_mask == '0));
endmodule

bind tag_inv_store tag_inv_checker #(
  .ADDR_W(ADDR_W), .SETS(SETS), .WAYS(WAYS), .SET_CLEAR(SET_CLEAR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .lk_hit(lk_hit), .lk_addr(lk_addr),
  .inv_valid(inv_valid), .inv_ready(inv_ready), .inv_addr(inv_addr),
  .sweep_req(sweep_req), .stg_mask(stg_mask)
);

// File: tb/sim_tag_inv_store.sv
module sim_tag_inv_store;
  localparam int AW = 16;
  localparam int LB = 16;
  localparam int NS = 8;
  localparam int NW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] lk_addr = '0, inv_addr = '0, fill_addr = '0;
  logic inv_valid = 1'b0, fill_en = 1'b0, sweep_req = 1'b0;
  logic fill_way = 1'b0;
  logic h0, h1, w0, w1, r0, r1, b0, b1;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tag_inv_store #(.ADDR_W(AW), .LINE_BYTES(LB), .SETS(NS), .WAYS(NW), .SET_CLEAR(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .lk_addr(lk_addr), .lk_hit(h0), .lk_way(w0),
    .inv_valid(inv_valid), .inv_addr(inv_addr), .inv_ready(r0),
    .fill_en(fill_en), .fill_way(fill_way), .fill_addr(fill_addr),
    .sweep_req(sweep_req), .busy(b0));

  tag_inv_store #(.ADDR_W(AW), .LINE_BYTES(LB), .SETS(NS), .WAYS(NW), .SET_CLEAR(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .lk_addr(lk_addr), .lk_hit(h1), .lk_way(w1),
    .inv_valid(inv_valid), .inv_addr(inv_addr), .inv_ready(r1),
    .fill_en(fill_en), .fill_way(fill_way), .fill_addr(fill_addr),
    .sweep_req(sweep_req), .busy(b1));

  // Behavioural reference: index [dut][set][way]
  bit mv [2][NS][NW];
  int mt [2][NS][NW];
  bit mbusy [2];
  int mcnt [2];
  bit sv [2];
  int sidx [2];
  bit smask [2][NW];

  function automatic int a_idx(logic [AW-1:0] a); return int'(a[7:4]) % NS; endfunction
  function automatic int a_tag(logic [AW-1:0] a); return int'(a) / (LB * NS); endfunction
  function automatic logic [AW-1:0] mk(int tag, int idx);
    return AW'(tag * LB * NS + idx * LB + 3);
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(string tag, logic [AW-1:0] la, bit iv, logic [AW-1:0] ia,
                      bit fe, int fw, logic [AW-1:0] fa, bit sw);
    lk_addr = la; inv_valid = iv; inv_addr = ia;
    fill_en = fe; fill_way = fw[0]; fill_addr = fa; sweep_req = sw;
    #1;
    for (int d = 0; d < 2; d++) begin
      int li = a_idx(la);
      int eh = 0, ew = 0;
      bit nm [NW];
      bit fire, ff;
      for (int w = NW - 1; w >= 0; w--)
        if (mv[d][li][w] && mt[d][li][w] == a_tag(la)) begin eh = 1; ew = w; end
      if (mbusy[d]) eh = 0;
      check(tag, d == 0 ? "u0.lk_hit" : "u1.lk_hit", d == 0 ? int'(h0) : int'(h1), eh);
      if (eh == 1) check(tag, d == 0 ? "u0.lk_way" : "u1.lk_way", d == 0 ? int'(w0) : int'(w1), ew);
      check(tag, d == 0 ? "u0.busy" : "u1.busy", d == 0 ? int'(b0) : int'(b1), int'(mbusy[d]));
      check(tag, d == 0 ? "u0.inv_ready" : "u1.inv_ready", d == 0 ? int'(r0) : int'(r1), int'(!mbusy[d]));
      // next state
      fire = iv && !mbusy[d];
      ff = fe && !mbusy[d];
      for (int w = 0; w < NW; w++)
        nm[w] = (d == 1) ? 1'b1 : (mv[d][a_idx(ia)][w] && mt[d][a_idx(ia)][w] == a_tag(ia));
      if (ff) begin mt[d][a_idx(fa)][fw] = a_tag(fa); mv[d][a_idx(fa)][fw] = 1'b1; end
      if (sv[d]) for (int w = 0; w < NW; w++) if (smask[d][w]) mv[d][sidx[d]][w] = 1'b0;
      if (mbusy[d]) for (int w = 0; w < NW; w++) mv[d][mcnt[d]][w] = 1'b0;
      sv[d] = fire; sidx[d] = a_idx(ia);
      for (int w = 0; w < NW; w++) smask[d][w] = fire && nm[w];
      if (mbusy[d]) begin
        if (mcnt[d] == NS - 1) begin mbusy[d] = 1'b0; mcnt[d] = 0; end
        else mcnt[d] = mcnt[d] + 1;
      end else if (sw) begin mbusy[d] = 1'b1; mcnt[d] = 0; end
    end
    @(negedge clk);
  endtask

  task automatic idle(string tag, logic [AW-1:0] la, int n);
    for (int i = 0; i < n; i++) step(tag, la, 0, '0, 0, 0, '0, 0);
  endtask

  task automatic fill(string tag, int w, logic [AW-1:0] a);
    step(tag, a, 0, '0, 1, w, a, 0);
  endtask

  task automatic inv(string tag, logic [AW-1:0] a, logic [AW-1:0] la);
    step(tag, la, 1, a, 0, 0, '0, 0);
  endtask

  localparam int TA = 9'h0A1, TB = 9'h0B2, TC = 9'h0C3;

  initial begin
    for (int d = 0; d < 2; d++) begin
      mbusy[d] = 1'b1; mcnt[d] = 0; sv[d] = 1'b0; sidx[d] = 0;
      for (int s = 0; s < NS; s++) for (int w = 0; w < NW; w++) begin
        mv[d][s][w] = 1'b0; mt[d][s][w] = 0; smask[d][w] = 1'b0;
      end
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R5: sweep length after reset, then all miss
    idle("R5", mk(TA, 2), NS + 3);
    // R9 fill, R3 lookup and way
    fill("R9", 0, mk(TA, 2));
    fill("R9", 1, mk(TB, 2));
    fill("R9", 1, mk(TA, 5));
    idle("R3", mk(TA, 2), 1);
    idle("R3", mk(TB, 2), 1);
    idle("R3", mk(TA, 5), 1);
    // R2 miss is a no-op in exact mode; R4 set clear in u1
    inv("R2", mk(TC, 2), mk(TA, 2));
    idle("R2", mk(TA, 2), 1);
    idle("R4", mk(TB, 2), 1);
    fill("R9", 0, mk(TA, 2));
    fill("R9", 1, mk(TB, 2));
    // R1 hit clears only its way; R8 write timing
    inv("R1", mk(TA, 2), mk(TA, 2));
    idle("R8", mk(TA, 2), 1);
    idle("R8", mk(TA, 2), 1);
    idle("R1", mk(TB, 2), 1);
    idle("R1", mk(TA, 5), 1);
    // R9 collision: invalidate write and fill on the same set and way
    fill("R9", 0, mk(TA, 2));
    inv("R9", mk(TA, 2), mk(TA, 2));
    fill("R9", 0, mk(TA, 2));
    idle("R9", mk(TA, 2), 2);
    // R6 software sweep; R7 traffic during busy is ignored
    for (int s = 0; s < NS; s++) fill("R6", s % 2, mk(TC, s));
    step("R6", mk(TC, 3), 0, '0, 0, 0, '0, 1);
    step("R7", mk(TC, 3), 1, mk(TC, 3), 1, 0, mk(TA, 4), 0);
    idle("R7", mk(TA, 4), NS - 2);
    for (int s = 0; s < NS; s++) idle("R6", mk(TC, s), 1);
    idle("R7", mk(TA, 4), 1);
    // R3 mixed traffic
    for (int i = 0; i < 2000; i++) begin
      int t = 1 + int'($urandom % 3);
      int s = int'($urandom % NS);
      int t2 = 1 + int'($urandom % 3);
      int s2 = int'($urandom % NS);
      step("R3", mk(t, s), ($urandom % 4) == 0, mk(t2, s2),
           ($urandom % 3) == 0, int'($urandom % 2), mk(1 + int'($urandom % 3), int'($urandom % NS)),
           ($urandom % 300) == 0);
    end
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog R5 actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule